// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which operating mode the processor core is in: normal run, HALT, or SLEEP. Each mode may also have the on-chip peripherals stopped by a separate stop bit. SLEEP combined with that stop bit gives full system stop. The instruction decoder signals a HALT or SLEEP instruction with a one-cycle strobe. From the mode and the stop bit, the block drives the clock enables for the CPU and the peripherals. It also drives the enables for DRAM refresh and DMA, the three status pins, and a control that parks the external bus.

While a low-power mode is active, the block checks for a wake-up event on every cycle of the free-running clock. The events are a falling edge on the non-maskable interrupt input and the maskable requests that pass their enable bits. The block uses the global interrupt enable to choose what happens next. The CPU clock enable returns one cycle after the deciding edge. In that same cycle the block gives a one-cycle action code: take the NMI, take the interrupt, or resume at the next instruction. The interrupt vectoring that follows is not part of this block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Reset puts the block in run mode and clears the stop bit. The outputs are then cpu_clk_en=1, per_clk_en=1, refresh_en=1, dma_en=1, halt_n=1, st=1, lir_n=1, bus_park=0, wake_valid=0 and wake_act=00. Reset also forces run mode from any low-power mode.
- R2: A halt_exec strobe in run mode enters HALT at the next edge. In HALT: cpu_clk_en=1, refresh_en=1, dma_en=1, bus_park=0, and the status triple (st, halt_n, lir_n) is (0,0,0).
- R3: A sleep_exec strobe in run mode enters SLEEP at the next edge. In SLEEP: cpu_clk_en=0, refresh_en=0, dma_en=0, bus_park=1, and the status triple (st, halt_n, lir_n) is (1,0,1).
- R4: A falling edge of nmi_n in HALT or SLEEP returns the block to run mode at that edge, with wake_act=01 (take NMI). The global enable has no effect on this. The NMI has priority over any maskable request in the same cycle.
- R5: In SLEEP, a request whose enable bit is 1 with ie_global=1 wakes the block with wake_act=10 (take interrupt).
- R6: In SLEEP, a request whose enable bit is 1 with ie_global=0 wakes the block with wake_act=11 (resume at next instruction).
- R7: A request whose enable bit is 0 is ignored, and the block stays in its low-power mode.
- R8: In HALT, an enabled request wakes the block with wake_act=10 only when ie_global=1. With ie_global=0 the block stays in HALT.
- R9: A stop_wr strobe loads stop_wdata into the stop bit. per_clk_en equals the inverse of the stop bit in every mode.
- R10: While the stop bit is 1, requests from the sources marked in PERIPH_MASK (default bits 7:4) cannot wake the block. Requests on the other bits still can. With the stop bit at 0, peripheral sources wake the block normally.
- R11: wake_valid is high for exactly one cycle per wake-up. In that cycle cpu_clk_en=1 and halt_n=1. At all other times wake_act=00.
- R12: halt_exec and sleep_exec strobes that arrive while the block is in a low-power mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; keeps running in SLEEP |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_exec | input | 1 | One-cycle strobe: HALT instruction executed |
| sleep_exec | input | 1 | One-cycle strobe: SLEEP instruction executed |
| stop_wr | input | 1 | Write strobe for the peripheral stop bit |
| stop_wdata | input | 1 | Value written to the stop bit |
| nmi_n | input | 1 | Non-maskable interrupt, active on falling edge |
| irq_req | input | N_IRQ | Maskable interrupt request levels |
| irq_en | input | N_IRQ | Individual enable per request |
| ie_global | input | 1 | Global maskable interrupt enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Serial/timer peripheral clock enable |
| refresh_en | output | 1 | DRAM refresh enable |
| dma_en | output | 1 | DMA engine enable |
| halt_n | output | 1 | Halt/sleep status pin, low in either mode |
| st | output | 1 | Status pin |
| lir_n | output | 1 | Instruction-load status pin |
| bus_park | output | 1 | Address high, controls inactive, data floated |
| wake_valid | output | 1 | One-cycle wake-up indication |
| wake_act | output | 2 | 00 none, 01 NMI, 10 interrupt, 11 resume |

## Verification
The assertions assume that halt_exec and sleep_exec never arrive in the same cycle. They also assume that the interrupt inputs are already synchronous to clk. The bench drives only one strobe per instruction, always on the falling clock edge, so every input is stable at the rising edge that samples it. Before each new falling edge on nmi_n, the bench returns the line to high for at least one cycle. This lets every NMI check see a single clean edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_HALT  = 2'd1,
    MODE_SLEEP = 2'd2
  } pmode_e;

  typedef enum logic [1:0] {
    WAKE_NONE   = 2'd0,
    WAKE_NMI    = 2'd1,
    WAKE_IRQ    = 2'd2,
    WAKE_RESUME = 2'd3
  } wake_e;
endpackage

// File: rtl/pwr_stop_reg.sv
module pwr_stop_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic stop
);
  always_ff @(posedge clk) begin
    if (!rst_n)  stop <= 1'b0;
    else if (wr) stop <= wdata;
  end
endmodule

// File: rtl/pwr_nmi_edge.sv
module pwr_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  output logic nmi_fall
);
  logic nmi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_prev <= 1'b1;
    else        nmi_prev <= nmi_n;
  end

  assign nmi_fall = nmi_prev & ~nmi_n;
endmodule

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter logic [N_IRQ-1:0] PERIPH_MASK = 8'hF0
) (
  input  pmode_e           mode,
  input  logic             stop,
  input  logic             nmi_fall,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             ie_global,
  output wake_e            decision
);
  logic [N_IRQ-1:0] live;

  // A stopped peripheral cannot raise a request
  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    if (PERIPH_MASK[i]) begin : g_per
      assign live[i] = irq_req[i] & irq_en[i] & ~stop;
    end else begin : g_ext
      assign live[i] = irq_req[i] & irq_en[i];
    end
  end

  logic any_live;
  assign any_live = |live;

  always_comb begin
    decision = WAKE_NONE;
    unique case (mode)
      MODE_HALT: begin
        if (nmi_fall)                   decision = WAKE_NMI;
        else if (any_live && ie_global) decision = WAKE_IRQ;
      end
      MODE_SLEEP: begin
        if (nmi_fall)      decision = WAKE_NMI;
        else if (any_live) decision = ie_global ? WAKE_IRQ : WAKE_RESUME;
      end
      default: decision = WAKE_NONE;
    endcase
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt_exec,
  input  logic   sleep_exec,
  input  wake_e  decision,
  output pmode_e mode,
  output logic   wake_valid,
  output wake_e  wake_act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= MODE_RUN;
      wake_valid <= 1'b0;
      wake_act   <= WAKE_NONE;
    end else begin
      wake_valid <= 1'b0;
      wake_act   <= WAKE_NONE;
      unique case (mode)
        MODE_RUN: begin
          if (halt_exec)       mode <= MODE_HALT;
          else if (sleep_exec) mode <= MODE_SLEEP;
        end
        default: begin
          if (decision != WAKE_NONE) begin
            mode       <= MODE_RUN;
            wake_valid <= 1'b1;
            wake_act   <= decision;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_mode_pkg::*;
(
  input  pmode_e mode,
  input  logic   stop,
  output logic   cpu_clk_en,
  output logic   per_clk_en,
  output logic   refresh_en,
  output logic   dma_en,
  output logic   halt_n,
  output logic   st,
  output logic   lir_n,
  output logic   bus_park
);
  assign per_clk_en = ~stop;

  always_comb begin
    cpu_clk_en = 1'b1;
    refresh_en = 1'b1;
    dma_en     = 1'b1;
    halt_n     = 1'b1;
    st         = 1'b1;
    lir_n      = 1'b1;
    bus_park   = 1'b0;
    unique case (mode)
      MODE_HALT: begin
        halt_n = 1'b0;
        st     = 1'b0;
        lir_n  = 1'b0;
      end
      MODE_SLEEP: begin
        cpu_clk_en = 1'b0;
        refresh_en = 1'b0;
        dma_en     = 1'b0;
        halt_n     = 1'b0;
        bus_park   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter logic [N_IRQ-1:0] PERIPH_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_exec,
  input  logic             sleep_exec,
  input  logic             stop_wr,
  input  logic             stop_wdata,
  input  logic             nmi_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             ie_global,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             refresh_en,
  output logic             dma_en,
  output logic             halt_n,
  output logic             st,
  output logic             lir_n,
  output logic             bus_park,
  output logic             wake_valid,
  output logic [1:0]       wake_act
);
  logic   stop;
  logic   nmi_fall;
  pmode_e mode;
  wake_e  decision;
  wake_e  act_q;

  pwr_stop_reg u_stop (
    .clk(clk), .rst_n(rst_n), .wr(stop_wr), .wdata(stop_wdata), .stop(stop)
  );

  pwr_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .nmi_fall(nmi_fall)
  );

  pwr_wake_eval #(.N_IRQ(N_IRQ), .PERIPH_MASK(PERIPH_MASK)) u_eval (
    .mode(mode), .stop(stop), .nmi_fall(nmi_fall), .irq_req(irq_req),
    .irq_en(irq_en), .ie_global(ie_global), .decision(decision)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .sleep_exec(sleep_exec),
    .decision(decision), .mode(mode), .wake_valid(wake_valid), .wake_act(act_q)
  );

  pwr_out_decode u_dec (
    .mode(mode), .stop(stop), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .refresh_en(refresh_en), .dma_en(dma_en), .halt_n(halt_n), .st(st),
    .lir_n(lir_n), .bus_park(bus_park)
  );

  assign wake_act = act_q;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nmi_n,
  input logic       cpu_clk_en,
  input logic       refresh_en,
  input logic       dma_en,
  input logic       halt_n,
  input logic       st,
  input logic       lir_n,
  input logic       bus_park,
  input logic       wake_valid,
  input logic [1:0] wake_act
);
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid); // R11

  AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (cpu_clk_en && halt_n && $past(!halt_n))); // R11

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_valid |-> (wake_act == 2'b00)); // R11

  AST_SLEEP_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (!refresh_en && !dma_en && bus_park && st && lir_n && !halt_n)); // R3

  AST_HALT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_n && !st) |-> (cpu_clk_en && refresh_en && dma_en && !bus_park && !lir_n)); // R2

  AST_NMI_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nmi_n) && !halt_n) |=> (wake_valid && wake_act == 2'b01)); // R4
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .cpu_clk_en(cpu_clk_en),
  .refresh_en(refresh_en), .dma_en(dma_en), .halt_n(halt_n), .st(st),
  .lir_n(lir_n), .bus_park(bus_park), .wake_valid(wake_valid), .wake_act(wake_act)
);

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_exec = 1'b0, sleep_exec = 1'b0;
  logic       stop_wr = 1'b0, stop_wdata = 1'b0;
  logic       nmi_n = 1'b1;
  logic [7:0] irq_req = 8'h00, irq_en = 8'h00;
  logic       ie_global = 1'b0;
  logic       cpu_clk_en, per_clk_en, refresh_en, dma_en;
  logic       halt_n, st, lir_n, bus_park, wake_valid;
  logic [1:0] wake_act;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pwr_mode_ctl uut (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .sleep_exec(sleep_exec),
    .stop_wr(stop_wr), .stop_wdata(stop_wdata), .nmi_n(nmi_n), .irq_req(irq_req),
    .irq_en(irq_en), .ie_global(ie_global), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .refresh_en(refresh_en), .dma_en(dma_en),
    .halt_n(halt_n), .st(st), .lir_n(lir_n), .bus_park(bus_park),
    .wake_valid(wake_valid), .wake_act(wake_act)
  );

  typedef struct packed {
    logic       slp;
    logic       stop;
    logic       ie;
    logic       nmi;
    logic [7:0] req;
    logic [7:0] en;
    logic [1:0] act;   // 0: stays in low-power mode
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 2'd2},  // R5
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 8'h02, 2'd3},  // R6
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h04, 8'h00, 2'd0},  // R7
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 2'd1},  // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h08, 8'h08, 2'd2},  // R8
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h08, 8'h08, 2'd0},  // R8
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 2'd1},  // R4
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h10, 8'h10, 2'd0},  // R10
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'h11, 8'h11, 2'd2},  // R10
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h10, 8'h10, 2'd2},  // R10
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h01, 2'd1},  // R4
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h20, 8'h20, 2'd0}   // R10
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic string vec_tag(input vec_t v);
    if (v.nmi)                           return "R4";
    if ((v.req & v.en & 8'hF0) != 8'h00) return "R10";
    if ((v.req & v.en) == 8'h00)         return "R7";
    if (!v.slp)                          return "R8";
    if (v.ie)                            return "R5";
    return "R6";
  endfunction

  task automatic run_vec(input vec_t v);
    string t;
    t = vec_tag(v);
    @(negedge clk); stop_wr = 1'b1; stop_wdata = v.stop;
    @(negedge clk); stop_wr = 1'b0;
    if (v.slp) sleep_exec = 1'b1; else halt_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0; halt_exec = 1'b0;
    check(v.slp ? "R3 cpu_clk_en" : "R2 cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, !v.slp});
    check(v.slp ? "R3 status" : "R2 status", {5'd0, st, halt_n, lir_n}, v.slp ? 8'h5 : 8'h0);
    check("R9 per_clk_en", {7'd0, per_clk_en}, {7'd0, !v.stop});
    irq_req = v.req; irq_en = v.en; ie_global = v.ie; nmi_n = !v.nmi;
    @(negedge clk);
    check({t, " wake_valid"}, {7'd0, wake_valid}, {7'd0, v.act != 2'd0});
    check({t, " wake_act"}, {6'd0, wake_act}, {6'd0, v.act});
    check({t, " halt_n"}, {7'd0, halt_n}, {7'd0, v.act != 2'd0});
    irq_req = 8'h00; irq_en = 8'h00; nmi_n = 1'b1;
    @(negedge clk);
    check("R11 pulse width", {7'd0, wake_valid}, 8'h0);
    if (v.act == 2'd0) begin
      check({t, " still low-power"}, {7'd0, halt_n}, 8'h0);
      nmi_n = 1'b0;
      @(negedge clk); nmi_n = 1'b1;
      check("R4 exit by NMI", {6'd0, wake_act}, 8'h1);
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs",
          {cpu_clk_en, per_clk_en, refresh_en, dma_en, halt_n, st, lir_n, bus_park}, 8'hFE);
    check("R1 reset wake", {5'd0, wake_valid, wake_act}, 8'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: stop bit write and clear
    @(negedge clk); stop_wr = 1'b1; stop_wdata = 1'b1;
    @(negedge clk); stop_wr = 1'b0;
    check("R9 stop set", {7'd0, per_clk_en}, 8'h0);
    stop_wr = 1'b1; stop_wdata = 1'b0;
    @(negedge clk); stop_wr = 1'b0;
    check("R9 stop clear", {7'd0, per_clk_en}, 8'h1);

    // R12: strobes in SLEEP ignored
    sleep_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0; halt_exec = 1'b1;
    @(negedge clk); halt_exec = 1'b0;
    check("R12 halt strobe in sleep", {5'd0, st, halt_n, cpu_clk_en}, 8'h4);
    sleep_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0;
    check("R12 sleep strobe in sleep", {6'd0, halt_n, wake_valid}, 8'h0);

    // R1: reset exits SLEEP with the stop bit set, clearing it
    stop_wr = 1'b1; stop_wdata = 1'b1;
    @(negedge clk); stop_wr = 1'b0;
    rst_n = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset from sleep",
          {cpu_clk_en, per_clk_en, refresh_en, dma_en, halt_n, st, lir_n, bus_park}, 8'hFE);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule